// File: doc/BRIEF.md
# Subframe Sync Mark Tracker

This block sits behind a bit decoder on a flight-data receive path. It takes one
recovered bit per `bit_valid` cycle. Each word is 12 bits, sent least significant bit
first. Every subframe opens with one of four fixed 12-bit marks. The tracker finds these
marks, checks that they arrive in the right order and at the programmed word spacing,
and only then declares frame lock. While locked it cuts the bit stream into words. It
hands each word to a receive FIFO together with its position in the subframe and the
subframe number. It also raises a match flag for the one word whose position and
subframe equal a programmed pair.

There are three modes. Full acquisition needs four correctly ordered marks, starting at
subframe 1, and locks on the next subframe-1 mark. Quick acquisition (`quick_mode`)
accepts any two consecutive, correctly ordered marks and locks on the third. Bypass
(`bypass_mode`) overrides both: it pushes every 12 raw bits without framing and keeps
the lock flag low.

The controller is a four-state machine:

- HUNT slides a 12-bit window over every new bit, looking for subframe 1 in full mode or any mark in quick mode.
- TRACK counts words from the first mark and checks each further mark at its exact boundary.
- LOCK stores words and keeps checking each mark.
- BYPASS pushes raw words.

The transitions are:

- HUNT→TRACK on a window hit.
- TRACK→LOCK when the last required mark matches.
- TRACK→HUNT or LOCK→HUNT when an expected mark is wrong or missing.
- any→BYPASS while `bypass_mode` is high.
- BYPASS→HUNT when it drops.

Top module: `sync_mark_tracker`

## Requirements
- R1: While `bypass_mode` is high (even with `quick_mode` high), `in_sync` is low from the next cycle. The state leaves framing. Each group of 12 valid bits counted from bypass entry is pushed as a raw word, first bit in bit 0, with `push_count` 0, `push_sub` 00 and `match` low.
- R2: In full mode, no word is pushed before lock. Marks for subframes 1, 2, 3 and 4 must be found in that order, each `words_per_sub` words after the previous one. The next subframe-1 mark at the right spacing sets `in_sync` and is the first word pushed.
- R3: The marks are 12'o1107, 12'o2670, 12'o5107 and 12'o6670 for subframes 1 to 4. Each word's first received bit lands in bit 0 of `push_word`.
- R4: Every pushed mark carries `push_count` 0 and `push_sub` 00, 01, 10 or 11 for subframes 1 to 4. The data words that follow carry counts 1 to `words_per_sub`−1 and the same `push_sub`. `push` is high for one cycle, in the cycle after the edge that takes in a word's last bit.
- R5: In quick mode, any mark starts the search. Two consecutive marks in order at the right spacing are required, and the third sets `in_sync` and is pushed as count 0.
- R6: If a mark is wrong or missing at its expected boundary, `in_sync` falls in the cycle after that word's last bit. No word is pushed until lock is regained, and the search restarts from subframe 1 (full mode).
- R7: `sub_code` takes the subframe code of each mark pushed while locked, and stays unchanged between mark pushes.
- R8: While locked, `match` goes high with the push of the word whose count equals `match_count` and whose subframe code equals `match_sub`. It stays high until the next word boundary, and it is low whenever `in_sync` is low.
- R9: In full mode, marks for subframes 2 to 4 met while hunting are ignored.
- R10: Cycles with `bit_valid` low do not shift the window or advance word timing.
- R11: After reset, `in_sync`, `push`, `match` and `sub_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received serial bit, LSB of each word first |
| quick_mode | input | 1 | Selects quick acquisition (two marks, lock on third) |
| bypass_mode | input | 1 | Push raw words without framing; overrides other modes |
| words_per_sub | input | CNT_W+1 | Words per subframe, mark included (2 or more) |
| match_count | input | CNT_W | Word count to flag |
| match_sub | input | 2 | Subframe code to flag |
| in_sync | output | 1 | Frame lock held |
| sub_code | output | 2 | Code of the last mark pushed while locked |
| push | output | 1 | One-cycle strobe: word record valid for the FIFO |
| push_word | output | 12 | Received word |
| push_count | output | CNT_W | Word position in subframe (mark = 0) |
| push_sub | output | 2 | Subframe code of the word |
| match | output | 1 | Programmed count and subframe reached |

## Verification
The bench keeps the default `CNT_W` of 13, so the count and match comparators have their full width. It drives `words_per_sub` to 6, which makes full acquisition, loss and reacquisition, quick acquisition and bypass all short enough for one run. The data words are drawn at random but never hold two adjacent ones, and they start and end with zero. Because every mark contains two adjacent ones, no sliding window that overlaps data can equal a mark. This makes the expected pushes exact. Random idle gaps between bits exercise the qualification by `bit_valid`.

// File: rtl/sync_trk_pkg.sv
package sync_trk_pkg;
    localparam int WORD_W = 12;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_TRACK  = 2'd1,
        ST_LOCK   = 2'd2,
        ST_BYPASS = 2'd3
    } trk_state_t;

    // Subframe marks, indexed by 2-bit subframe code.
    function automatic logic [WORD_W-1:0] mark_of(input logic [1:0] code);
        logic [WORD_W-1:0] m;
        unique case (code)
            2'd0: m = 12'o1107;
            2'd1: m = 12'o2670;
            2'd2: m = 12'o5107;
            default: m = 12'o6670;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/stm_window.sv
module stm_window
    import sync_trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    output logic [WORD_W-1:0] win,
    output logic [3:0]        hit
);
    logic [WORD_W-1:0] shreg;

    // Newest bit enters at the top; after 12 bits the first bit sits in bit 0.
    assign win = {bit_in, shreg[WORD_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            shreg <= '0;
        else if (bit_valid)
            shreg <= win;
    end

    for (genvar k = 0; k < 4; k++) begin : g_cmp
        assign hit[k] = (win == mark_of(2'(k)));
    end
endmodule

// File: rtl/stm_slot_timer.sv
module stm_slot_timer
    import sync_trk_pkg::*;
#(
    parameter int CNT_W  = 13,
    localparam int RATE_W = CNT_W + 1,
    localparam int BC_W   = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_valid,
    input  logic [RATE_W-1:0] words_per_sub,
    output logic              word_done,
    output logic              at_mark,
    output logic [RATE_W-1:0] next_pos
);
    logic [BC_W-1:0]   bcnt;
    logic [RATE_W-1:0] pos;

    assign next_pos  = pos + RATE_W'(1);
    assign at_mark   = (next_pos == words_per_sub);
    assign word_done = bit_valid && !clear && (bcnt == BC_W'(WORD_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0;
            pos  <= '0;
        end else if (clear) begin
            bcnt <= '0;
            pos  <= '0;
        end else if (bit_valid) begin
            if (bcnt == BC_W'(WORD_W - 1)) begin
                bcnt <= '0;
                pos  <= at_mark ? '0 : next_pos;
            end else begin
                bcnt <= bcnt + BC_W'(1);
            end
        end
    end
endmodule

// File: rtl/sync_mark_tracker.sv
module sync_mark_tracker
    import sync_trk_pkg::*;
#(
    parameter int CNT_W  = 13,
    localparam int RATE_W = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              quick_mode,
    input  logic              bypass_mode,
    input  logic [RATE_W-1:0] words_per_sub,
    input  logic [CNT_W-1:0]  match_count,
    input  logic [1:0]        match_sub,
    output logic              in_sync,
    output logic [1:0]        sub_code,
    output logic              push,
    output logic [WORD_W-1:0] push_word,
    output logic [CNT_W-1:0]  push_count,
    output logic [1:0]        push_sub,
    output logic              match
);
    trk_state_t        state, nxt;
    logic [WORD_W-1:0] win;
    logic [3:0]        hit;
    logic              word_done, at_mark, tmr_clear;
    logic [RATE_W-1:0] next_pos;
    logic [2:0]        seen, need;
    logic [1:0]        exp_idx, found;
    logic              hunt_hit, mark_ok;

    stm_window u_win (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .win(win), .hit(hit)
    );

    assign tmr_clear = (state == ST_HUNT) || (bypass_mode && state != ST_BYPASS);

    stm_slot_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .bit_valid(bit_valid),
        .words_per_sub(words_per_sub), .word_done(word_done),
        .at_mark(at_mark), .next_pos(next_pos)
    );

    always_comb begin
        found = 2'd0;
        for (int k = 3; k >= 0; k--)
            if (hit[k]) found = 2'(k);
    end

    assign need     = quick_mode ? 3'd2 : 3'd4;
    assign hunt_hit = bit_valid && (quick_mode ? (|hit) : hit[0]);
    assign mark_ok  = hit[exp_idx];
    assign in_sync  = (state == ST_LOCK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= nxt;
    end

    // Next state
    always_comb begin
        nxt = state;
        if (bypass_mode) begin
            nxt = ST_BYPASS;
        end else begin
            unique case (state)
                ST_HUNT:   if (hunt_hit) nxt = ST_TRACK;
                ST_TRACK:  if (word_done && at_mark) begin
                               if (!mark_ok)          nxt = ST_HUNT;
                               else if (seen == need) nxt = ST_LOCK;
                           end
                ST_LOCK:   if (word_done && at_mark && !mark_ok) nxt = ST_HUNT;
                ST_BYPASS: nxt = ST_HUNT;
            endcase
        end
    end

    // Outputs and tracking registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            push       <= 1'b0;
            push_word  <= '0;
            push_count <= '0;
            push_sub   <= '0;
            sub_code   <= '0;
            match      <= 1'b0;
            seen       <= '0;
            exp_idx    <= '0;
        end else begin
            push <= 1'b0;
            if (bypass_mode) begin
                if (state != ST_BYPASS) match <= 1'b0;
            end
            unique case (state)
                ST_HUNT: if (hunt_hit && !bypass_mode) begin
                    seen    <= 3'd1;
                    exp_idx <= found + 2'd1;
                end
                ST_TRACK: if (word_done && at_mark && mark_ok && !bypass_mode) begin
                    exp_idx <= exp_idx + 2'd1;
                    if (seen == need) begin
                        push       <= 1'b1;
                        push_word  <= win;
                        push_count <= '0;
                        push_sub   <= exp_idx;
                        sub_code   <= exp_idx;
                        match      <= (match_count == '0) && (match_sub == exp_idx);
                    end else begin
                        seen <= seen + 3'd1;
                    end
                end
                ST_LOCK: if (word_done && !bypass_mode) begin
                    if (at_mark) begin
                        if (mark_ok) begin
                            push       <= 1'b1;
                            push_word  <= win;
                            push_count <= '0;
                            push_sub   <= exp_idx;
                            sub_code   <= exp_idx;
                            exp_idx    <= exp_idx + 2'd1;
                            match      <= (match_count == '0) && (match_sub == exp_idx);
                        end else begin
                            match <= 1'b0;
                        end
                    end else begin
                        push       <= 1'b1;
                        push_word  <= win;
                        push_count <= CNT_W'(next_pos);
                        push_sub   <= sub_code;
                        match      <= (match_count == CNT_W'(next_pos)) && (match_sub == sub_code);
                    end
                end
                ST_BYPASS: begin
                    match <= 1'b0;
                    if (word_done) begin
                        push       <= 1'b1;
                        push_word  <= win;
                        push_count <= '0;
                        push_sub   <= 2'd0;
                    end
                end
            endcase
        end
    end

    AST_BYPASS_NOSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_mode |=> !in_sync); // R1
    AST_SYNC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> (push && push_count == '0)); // R2
    AST_MARK_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && in_sync && push_count == '0) |-> (push_word == mark_of(push_sub))); // R3
    AST_PUSH_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (in_sync || $past(state == ST_BYPASS))); // R6
    AST_SUBCODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !(push && push_count == '0)) |-> $stable(sub_code)); // R7
    AST_MATCH_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> in_sync); // R8
endmodule

// File: tb/tb_sync_mark_tracker.sv
module tb_sync_mark_tracker;
    localparam int CNT_W = 13;
    localparam int NW    = 6;
    localparam logic [CNT_W-1:0] MC = 13'd3;
    localparam logic [1:0]       MS = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0, bit_in = 1'b0, quick_mode = 1'b0, bypass_mode = 1'b0;
    logic [CNT_W:0]   words_per_sub = (CNT_W+1)'(NW);
    logic [CNT_W-1:0] match_count = MC;
    logic [1:0]       match_sub = MS;
    logic in_sync, push, match;
    logic [1:0] sub_code, push_sub;
    logic [11:0] push_word;
    logic [CNT_W-1:0] push_count;

    sync_mark_tracker #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .quick_mode(quick_mode), .bypass_mode(bypass_mode),
        .words_per_sub(words_per_sub), .match_count(match_count), .match_sub(match_sub),
        .in_sync(in_sync), .sub_code(sub_code), .push(push), .push_word(push_word),
        .push_count(push_count), .push_sub(push_sub), .match(match)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0, match_pulses = 0;
    logic [11:0] ew [0:511];
    int          ec [0:511];
    logic [1:0]  es [0:511];
    int e_wr = 0, e_rd = 0;
    logic mflag = 1'b0;
    string cur_tag = "R4";

    function automatic logic [11:0] tb_mark(input int k);
        case (k)
            0: return 12'o1107;
            1: return 12'o2670;
            2: return 12'o5107;
            default: return 12'o6670;
        endcase
    endfunction

    // Data words with no adjacent ones and zero end bits: never form a mark.
    function automatic logic [11:0] rnd_data();
        logic [11:0] r, w;
        r = 12'($urandom);
        w = r & ~(r << 1);
        w[0] = 1'b0;
        w[11] = 1'b0;
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_rec(input logic [11:0] w, input int c, input logic [1:0] s);
        ew[e_wr] = w; ec[e_wr] = c; es[e_wr] = s;
        e_wr++;
    endtask

    // Monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (push) begin
                if (e_rd >= e_wr) begin
                    chk(0, "R6 unexpected push", longint'(push_word), 0);
                end else begin
                    chk(push_word == ew[e_rd] && push_count == CNT_W'(ec[e_rd]) && push_sub == es[e_rd],
                        cur_tag, {push_word, 2'b00, push_sub, 3'b000, push_count},
                        {ew[e_rd], 2'b00, es[e_rd], 3'b000, CNT_W'(ec[e_rd])});
                    e_rd++;
                end
                if (in_sync && push_count == '0)
                    chk(sub_code == push_sub, "R7 sub_code", sub_code, push_sub);
                mflag = in_sync && push_count == MC && push_sub == MS;
                if (match) match_pulses++;
            end
            if (!in_sync) mflag = 1'b0;
            chk(match == (mflag && in_sync), "R8 match", match, mflag && in_sync);
        end
    end

    task automatic send_bit(input logic b);
        int gap = $urandom_range(0, 2);
        repeat (gap) begin
            @(negedge clk);
            bit_valid = 1'b0;   // R10: idle cycles between bits
        end
        @(negedge clk);
        bit_valid = 1'b1;
        bit_in = b;
    endtask

    task automatic send_word(input logic [11:0] w);
        for (int i = 0; i < 12; i++) send_bit(w[i]);
    endtask

    task automatic send_sub(input int k, input bit store, input bit bad);
        logic [11:0] m;
        m = bad ? rnd_data() : tb_mark(k);
        send_word(m);
        if (store) expect_rec(m, 0, 2'(k));
        for (int j = 1; j < NW; j++) begin
            logic [11:0] d;
            d = rnd_data();
            send_word(d);
            if (store) expect_rec(d, j, 2'(k));
        end
    endtask

    task automatic flush(input string tag);
        @(negedge clk);
        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(e_rd == e_wr, tag, e_rd, e_wr);
    endtask

    task automatic do_reset(input logic q, input logic byp);
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        quick_mode = q;
        bypass_mode = byp;
        e_wr = 0; e_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset(1'b0, 1'b0);
        // R11 reset state
        chk(!in_sync && !push && !match && sub_code == 2'd0, "R11 reset", {in_sync, push, match, sub_code}, 0);

        // R2 full acquisition; R9 early marks of subframes 2..4 ignored
        cur_tag = "R2/R4 full record";
        send_word(12'h000);
        send_word(12'h000);
        send_sub(1, 0, 0);
        send_sub(3, 0, 0);
        for (int k = 0; k < 4; k++) send_sub(k, 0, 0);
        flush("R9 no push while acquiring");
        chk(!in_sync, "R2 not yet in sync", in_sync, 0);
        for (int k = 0; k < 4; k++) send_sub(k, 1, 0);
        send_sub(0, 1, 0);
        flush("R2 stored words");
        chk(in_sync, "R2 in sync", in_sync, 1);
        chk(match_pulses == 1, "R8 match pulse count", match_pulses, 1);
        chk(sub_code == 2'd0, "R7 sub_code after subframe 1", sub_code, 0);

        // R6 loss on a missing mark, then reacquire
        cur_tag = "R6 reacquire record";
        send_sub(1, 0, 1);
        flush("R6 nothing stored after loss");
        chk(!in_sync, "R6 sync dropped", in_sync, 0);
        send_sub(2, 0, 0);
        send_sub(3, 0, 0);
        for (int k = 0; k < 4; k++) send_sub(k, 0, 0);
        send_sub(0, 1, 0);
        flush("R6 reacquired stores");
        chk(in_sync, "R6 in sync again", in_sync, 1);
        // R6 loss on an out-of-order mark
        send_sub(2, 0, 0);
        flush("R6 wrong order no store");
        chk(!in_sync, "R6 wrong order drops sync", in_sync, 0);

        // R5 quick acquisition from subframe 2
        do_reset(1'b1, 1'b0);
        cur_tag = "R5 quick record";
        send_word(12'h000);
        send_sub(1, 0, 0);
        send_sub(2, 0, 0);
        chk(!in_sync, "R5 not in sync after two marks", in_sync, 0);
        send_sub(3, 1, 0);
        send_sub(0, 1, 0);
        flush("R5 quick stores");
        chk(in_sync, "R5 in sync", in_sync, 1);
        chk(sub_code == 2'd0, "R7 quick sub_code", sub_code, 0);

        // R1 bypass overrides quick mode
        do_reset(1'b1, 1'b1);
        cur_tag = "R1 bypass record";
        send_word(tb_mark(0));
        expect_rec(tb_mark(0), 0, 2'd0);
        for (int i = 0; i < 6; i++) begin
            logic [11:0] w;
            w = 12'($urandom);
            send_word(w);
            expect_rec(w, 0, 2'd0);
        end
        send_word(tb_mark(1));
        expect_rec(tb_mark(1), 0, 2'd0);
        flush("R1 bypass stores");
        chk(!in_sync, "R1 in_sync low in bypass", in_sync, 0);
        chk(!match, "R1 match low in bypass", match, 0);

        finish_run();
    end
endmodule